// File: doc/BRIEF.md
# Slice-Addressed Register File

This block holds sixteen 32-bit words. Each access moves a single 8-bit slice of a word, never the whole word. One shared slice selector picks the slice, and it applies to every access in a cycle. There is one synchronous write port and two read ports. The read ports are purely combinational: each returns the selected slice of the word at its own address in the same cycle, with no latency.

Word 0 is a constant zero. Writes aimed at it are dropped, and a read port addressed to 0 always returns zero. There is no forwarding from the write port to the read ports. The full contents are also exported as a packed debug vector, so surrounding logic can observe the whole array.

The active-low reset takes effect asynchronously and clears every stored word. It must be released synchronously to the clock.

Top module: `slice_regfile`

## Requirements
- R1: Slice k of a word is bits [8k+7:8k] of that word. With `slice_sel` = k, a read port returns exactly those bits of the word at its address, as seen in `dbg_words`.
- R2: A read port output follows changes of its address and of `slice_sel` within the same cycle, with no clock edge needed.
- R3: On a rising edge with `wr_en` = 1, `rst_n` = 1 and `wr_addr` != 0, slice `slice_sel` of word `wr_addr` takes `wr_data`. Every other slice of that word and every other word keeps its value.
- R4: On a rising edge with `wr_en` = 0 and `rst_n` = 1, the whole array is unchanged.
- R5: A write addressed to word 0 changes nothing. Word 0 of `dbg_words` reads zero at all times.
- R6: A read port whose address is 0 outputs zero at all times, including at power-on before any reset and after attempted writes to word 0.
- R7: While `rst_n` is low, every word reads zero no later than the next rising edge. Reset wins over a write in the same cycle.
- R8: A read of the word being written in the same cycle returns the value held before that clock edge.
- R9: `dbg_words[n]` is the stored word n for every n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserts asynchronously, clears the array |
| slice_sel | input | 2 | Slice used by every access this cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Word written |
| wr_data | input | 8 | Slice value written |
| rd_addr | input | 2x4 | Read address, one per read port |
| rd_data | output | 2x8 | Read slice, one per read port |
| dbg_words | output | 16x32 | All stored words, word n at index n |

## Verification
The bench builds the block with its default parameters: 16 words, 4 slices of 8 bits, and 2 read ports. At this size, a write to every one of the 64 word/slice pairs and a read of every pair through both ports fit into a short run. That sweep covers the slice layout, reads of address 0, and same-address read/write on every word. A long random phase with reset pulses and frequent writes to word 0 then compares both ports and the full debug vector against an arithmetic model each cycle.

// File: rtl/slice_regfile_pkg.sv
package slice_regfile_pkg;
  localparam int unsigned RF_DATA_W   = 32;
  localparam int unsigned RF_SLICE_W  = 8;
  localparam int unsigned RF_NUM_WORDS = 16;
  localparam int unsigned RF_NUM_RD   = 2;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
  parameter int unsigned NUM_WORDS  = 16,
  parameter int unsigned NUM_SLICES = 4,
  localparam int unsigned ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned SEL_W  = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [SEL_W-1:0]                       slice_sel,
  output logic [NUM_WORDS-1:0][NUM_SLICES-1:0]   slice_we
);

  always_comb begin
    slice_we = '0;
    if (wr_en && (wr_addr != '0) && (int'(wr_addr) < NUM_WORDS)
        && (int'(slice_sel) < NUM_SLICES)) begin
      slice_we[wr_addr][slice_sel] = 1'b1;
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slice_we)); // R3

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (slice_we == '0)); // R4

endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SLICE_W = 8,
  localparam int unsigned NUM_SLICES = DATA_W / SLICE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] slice_we,
  input  logic [SLICE_W-1:0]    wr_data,
  output logic [DATA_W-1:0]     word_q
);

  logic [DATA_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    word_d  = word_q;
    word_en = |slice_we;
    for (int k = 0; k < int'(NUM_SLICES); k++) begin
      if (slice_we[k]) begin
        word_d[k*SLICE_W +: SLICE_W] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  for (genvar k = 0; k < int'(NUM_SLICES); k++) begin : g_slice_chk
    AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_we[k] |=> $stable(word_q[k*SLICE_W +: SLICE_W])); // R3
    AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      slice_we[k] |=> (word_q[k*SLICE_W +: SLICE_W] == $past(wr_data))); // R3
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SLICE_W   = 8,
  parameter int unsigned NUM_WORDS = 16,
  localparam int unsigned NUM_SLICES = DATA_W / SLICE_W,
  localparam int unsigned ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned SEL_W  = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0]  words,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [SEL_W-1:0]                  slice_sel,
  output logic [SLICE_W-1:0]                data
);

  always_comb begin
    data = '0;
    if ((addr != '0) && (int'(addr) < NUM_WORDS) && (int'(slice_sel) < NUM_SLICES)) begin
      data = words[addr][int'(slice_sel)*SLICE_W +: SLICE_W];
    end
  end

  AST_RD_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (data == '0)); // R6

endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
  import slice_regfile_pkg::*;
#(
  parameter int unsigned DATA_W    = RF_DATA_W,
  parameter int unsigned SLICE_W   = RF_SLICE_W,
  parameter int unsigned NUM_WORDS = RF_NUM_WORDS,
  parameter int unsigned NUM_RD    = RF_NUM_RD,
  localparam int unsigned NUM_SLICES = DATA_W / SLICE_W,
  localparam int unsigned ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned SEL_W  = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SEL_W-1:0]                  slice_sel,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [SLICE_W-1:0]                wr_data,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]     rd_addr,
  output logic [NUM_RD-1:0][SLICE_W-1:0]    rd_data,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  dbg_words
);

  logic [NUM_WORDS-1:0][NUM_SLICES-1:0] slice_we;
  logic [NUM_WORDS-1:0][DATA_W-1:0]     words;

  rf_write_decode #(
    .NUM_WORDS  (NUM_WORDS),
    .NUM_SLICES (NUM_SLICES)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .slice_sel (slice_sel),
    .slice_we  (slice_we)
  );

  for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_word
    if (w == 0) begin : g_zero
      assign words[w] = '0;
    end else begin : g_store
      rf_word #(
        .DATA_W  (DATA_W),
        .SLICE_W (SLICE_W)
      ) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .slice_we (slice_we[w]),
        .wr_data  (wr_data),
        .word_q   (words[w])
      );
    end
  end

  for (genvar p = 0; p < int'(NUM_RD); p++) begin : g_rd
    rf_read_port #(
      .DATA_W    (DATA_W),
      .SLICE_W   (SLICE_W),
      .NUM_WORDS (NUM_WORDS)
    ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .words     (words),
      .addr      (rd_addr[p]),
      .slice_sel (slice_sel),
      .data      (rd_data[p])
    );
  end

  assign dbg_words = words;

  AST_WORD0_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_we[0] == '0)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dbg_words)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbg_words == '0)); // R7

endmodule

// File: tb/slice_regfile_tb.sv
`timescale 1ns/1ps
module slice_regfile_tb;

  logic             clk;
  logic             rst_n;
  logic [1:0]       slice_sel;
  logic             wr_en;
  logic [3:0]       wr_addr;
  logic [7:0]       wr_data;
  logic [1:0][3:0]  rd_addr;
  logic [1:0][7:0]  rd_data;
  logic [15:0][31:0] dbg_words;

  logic [31:0] model [16];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  slice_regfile u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .slice_sel (slice_sel),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .dbg_words (dbg_words)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] exp_slice(input logic [3:0] a, input logic [1:0] s);
    if (a == 4'd0) return 8'h00;
    return model[a][s*8 +: 8];
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_array(input string tag);
    checks++;
    for (int n = 0; n < 16; n++) begin
      if (dbg_words[n] !== model[n]) begin
        errors++;
        $display("FAIL %s: word %0d actual %08h expected %08h", tag, n, dbg_words[n], model[n]);
        break;
      end
    end
  endtask

  // One cycle: drive at negedge, check reads before the edge, array after it.
  task automatic cyc(input logic en, input logic [3:0] wa, input logic [7:0] wd,
                     input logic [1:0] ss, input logic [3:0] ra0, input logic [3:0] ra1,
                     input logic rn, input string tag);
    @(negedge clk);
    wr_en = en; wr_addr = wa; wr_data = wd; slice_sel = ss;
    rd_addr[0] = ra0; rd_addr[1] = ra1; rst_n = rn;
    if (!rn) for (int n = 0; n < 16; n++) model[n] = '0; // R7 asynchronous clear
    #1;
    // R1 R2 R6 R8: combinational read of pre-edge contents
    chk8({tag, " R1/R2/R6/R8 port0"}, rd_data[0], exp_slice(ra0, ss));
    chk8({tag, " R1/R2/R6/R8 port1"}, rd_data[1], exp_slice(ra1, ss));
    @(posedge clk);
    if (rn && en && wa != 4'd0) model[wa][ss*8 +: 8] = wd; // R3, R5 drops word 0
    #1;
    chk_array({tag, " R3/R4/R5/R7/R9 array"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 16; n++) model[n] = '0;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; slice_sel = '0;
    rd_addr[0] = 4'd0; rd_addr[1] = 4'd0;
    #1;
    // R6 at power-on, before any reset
    chk8("power-on R6 port0", rd_data[0], 8'h00);
    slice_sel = 2'd3; #1;
    chk8("power-on R6 port1", rd_data[1], 8'h00);
    rst_n = 1'b0;
    cyc(1'b0, 4'd0, 8'h00, 2'd0, 4'd0, 4'd1, 1'b0, "reset");
    cyc(1'b0, 4'd0, 8'h00, 2'd0, 4'd2, 4'd3, 1'b1, "reset release R7");

    // Sweep: write every word/slice, port 0 reads the same word (R8)
    for (int w = 0; w < 16; w++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1'b1, 4'(w), 8'((w*16 + s*4 + 1) ^ 8'hA5), 2'(s), 4'(w), 4'(15 - w), 1'b1, "sweep write R3/R8");
      end
    end
    // Sweep: idle reads of every word/slice on both ports (R1, R4)
    for (int w = 0; w < 16; w++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1'b0, 4'(w), 8'hFF, 2'(s), 4'(w), 4'((w + 5) % 16), 1'b1, "sweep read R1/R4");
      end
    end
    // Writes to word 0 with every slice, read back via address 0 (R5, R6)
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 4'd0, 8'hFF, 2'(s), 4'd0, 4'd0, 1'b1, "word0 write R5/R6");
    end
    // Reset asserted together with a write (R7 priority)
    cyc(1'b1, 4'd7, 8'h3C, 2'd2, 4'd7, 4'd7, 1'b0, "reset vs write R7");
    cyc(1'b0, 4'd7, 8'h00, 2'd2, 4'd7, 4'd0, 1'b1, "after reset R7");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] wa;
      logic [3:0] r0;
      wa = ($urandom % 5 == 0) ? 4'd0 : 4'($urandom);
      r0 = ($urandom % 3 == 0) ? wa : 4'($urandom);
      cyc(($urandom % 4) != 0, wa, 8'($urandom), 2'($urandom), r0, 4'($urandom),
          ($urandom % 80) != 0, "random R3/R8");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule